// File: doc/BRIEF.md
# Burst Read Word Assembler

This block sits on the bus side of an octal double-rate read path. On the capture side it joins pairs of 16-bit half-words into 32-bit words and pushes each finished word into an external receive FIFO. On the bus side it serves burst reads from that FIFO. The FIFO is first-word-fall-through: the head word is valid whenever the FIFO is not empty.

A read beat is accepted when the FIFO holds a word. The word is popped and the beat is acknowledged on the following cycle. For each delivered word the block sends a one-cycle increment to the shared next-read address pointer, which is kept outside the block.

The cycle-type tag decides whether the burst goes on. Writes are acknowledged at once and their data is dropped, so the bus never stalls on them.

Top module: `burst_rd_asm`

## Requirements
- R1: Two consecutive accepted half-words become one word. The first half goes in bits [15:0] and the second in bits [31:16]. `fifo_wr_en` pulses for one cycle, on the cycle after the second half is taken.
- R2: A read beat needs `bus_cyc`=1, `bus_stb`=1, `bus_we`=0 and `fifo_empty`=0. It is acknowledged one cycle after it is accepted. While the FIFO is empty, no read acknowledge is given and no pop is made.
- R3: Each accepted read beat pulses `fifo_rd_en` for exactly one cycle. The acknowledge returns, on `bus_rdata`, the FIFO head word at the moment of that pop.
- R4: `ptr_inc` pulses for one cycle together with every read acknowledge. It never pulses for a write.
- R5: A beat taken with tag 3'b010 (incrementing) keeps the burst open. A beat taken with any other tag, including 3'b111 (end of burst), is acknowledged. After it, no read is accepted until `bus_cyc` has gone low.
- R6: A write beat (`bus_we`=1) is acknowledged one cycle after it is presented. It causes no FIFO pop and no pointer increment.
- R7: `bus_ack` is high only in the cycle after one in which `bus_cyc` and `bus_stb` were both high. It is never high for two cycles in a row.
- R8: After reset, `bus_ack`, `fifo_rd_en`, `ptr_inc` and `fifo_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | A captured half-word is present |
| cap_half | input | 16 | Captured half-word |
| fifo_wr_en | output | 1 | Push the assembled word into the FIFO |
| fifo_wr_data | output | 32 | Assembled word |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Beat strobe |
| bus_we | input | 1 | Write beat |
| bus_cti | input | 3 | Cycle-type tag |
| bus_ack | output | 1 | Beat acknowledge |
| bus_rdata | output | 32 | Read data |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_en | output | 1 | Pop the FIFO head |
| fifo_rd_data | input | 32 | FIFO head word, valid when not empty |
| ptr_inc | output | 1 | Advance the next-read pointer by one word |

## Verification
The assertions rely on the bus master holding `bus_cyc` and `bus_stb` high until it sees the acknowledge. They also rely on the FIFO never reporting non-empty without a valid head word, and on the FIFO taking a pop only in the cycle that `fifo_rd_en` is high.

The bench keeps to these rules. Its behavioural FIFO updates its queue just after each clock edge, using enables sampled in the middle of the preceding cycle. Bus tasks hold each request until the acknowledge is seen and only then release the strobe. Capture data goes in strictly in pairs, so every half-word sequence ends on a word boundary.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  typedef enum logic [2:0] {
    CTI_CLASSIC = 3'd0,
    CTI_CONST   = 3'd1,
    CTI_INCR    = 3'd2,
    CTI_EOB     = 3'd7
  } cti_e;

  // A beat keeps the burst open only when tagged as incrementing.
  function automatic logic tag_continues(input logic [2:0] tag);
    return tag == CTI_INCR;
  endfunction

endpackage

// File: rtl/half_packer.sv
module half_packer #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              second_half
);

  // First-received half lands in the low bits.
  function automatic logic [WORD_W-1:0] pack_halves(
    input logic [HALF_W-1:0] first,
    input logic [HALF_W-1:0] second
  );
    return {second, first};
  endfunction

  logic              phase_q;
  logic [HALF_W-1:0] low_q;

  assign second_half = in_valid && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      low_q     <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= second_half;
      if (in_valid) begin
        phase_q <= ~phase_q;
        if (!phase_q) begin
          low_q <= in_half;
        end else begin
          out_word <= pack_halves(low_q, in_half);
        end
      end
    end
  end

endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_rd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic [TAG_W-1:0]  tag,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic              pop,
  output logic              ack,
  output logic [WORD_W-1:0] rdata,
  output logic              inc,
  output logic              read_go,
  output logic              write_go,
  output logic              held
);

  logic              ack_q;
  logic              inc_q;
  logic              hold_q;
  logic [WORD_W-1:0] dat_q;

  always_comb begin
    read_go  = cyc && stb && !we && !ack_q && !hold_q && !empty;
    write_go = cyc && stb &&  we && !ack_q;
  end

  assign pop   = read_go;
  assign ack   = ack_q;
  assign inc   = inc_q;
  assign rdata = dat_q;
  assign held  = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      inc_q  <= 1'b0;
      hold_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      ack_q <= read_go || write_go;
      inc_q <= read_go;
      if (read_go) begin
        dat_q <= head;
      end
      if (!cyc) begin
        hold_q <= 1'b0;
      end else if (read_go && !tag_continues(3'(tag))) begin
        hold_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_rd_asm.sv
module burst_rd_asm #(
  parameter int HALF_W = 16,
  parameter int TAG_W  = 3,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [HALF_W-1:0] cap_half,
  output logic              fifo_wr_en,
  output logic [WORD_W-1:0] fifo_wr_data,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [TAG_W-1:0]  bus_cti,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [WORD_W-1:0] fifo_rd_data,
  output logic              ptr_inc
);

  // Internal events brought out for the checker.
  logic beat_accept;
  logic write_accept;
  logic hold_off;
  logic pair_done;

  half_packer #(.HALF_W(HALF_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (cap_valid),
    .in_half     (cap_half),
    .out_valid   (fifo_wr_en),
    .out_word    (fifo_wr_data),
    .second_half (pair_done)
  );

  beat_ctrl #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (bus_cyc),
    .stb      (bus_stb),
    .we       (bus_we),
    .tag      (bus_cti),
    .empty    (fifo_empty),
    .head     (fifo_rd_data),
    .pop      (fifo_rd_en),
    .ack      (bus_ack),
    .rdata    (bus_rdata),
    .inc      (ptr_inc),
    .read_go  (beat_accept),
    .write_go (write_accept),
    .held     (hold_off)
  );

endmodule

// File: rtl/burst_rd_asm_chk.sv
module burst_rd_asm_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_valid,
  input logic             fifo_wr_en,
  input logic             pair_done,
  input logic             bus_cyc,
  input logic             bus_stb,
  input logic             bus_we,
  input logic [TAG_W-1:0] bus_cti,
  input logic             bus_ack,
  input logic             fifo_empty,
  input logic             fifo_rd_en,
  input logic             ptr_inc,
  input logic             beat_accept,
  input logic             write_accept,
  input logic             hold_off
);

  AST_PUSH_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> $past(cap_valid && pair_done)); // R1

  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty); // R2

  AST_POP_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |=> (bus_ack && ptr_inc && !fifo_rd_en)); // R3

  AST_INC_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |-> (bus_ack && $past(beat_accept))); // R4

  AST_EOB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_accept && bus_cti != TAG_W'(2)) |=> (bus_cyc |-> hold_off)); // R5

  AST_HOLD_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_off && bus_cyc) |-> !beat_accept); // R5

  AST_WRITE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && bus_we) |-> !fifo_rd_en); // R6

  AST_WRITE_ACK_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    write_accept |=> (bus_ack && !ptr_inc)); // R6

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_cyc && bus_stb)); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R7

endmodule

bind burst_rd_asm burst_rd_asm_chk #(.TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_valid    (cap_valid),
  .fifo_wr_en   (fifo_wr_en),
  .pair_done    (pair_done),
  .bus_cyc      (bus_cyc),
  .bus_stb      (bus_stb),
  .bus_we       (bus_we),
  .bus_cti      (bus_cti),
  .bus_ack      (bus_ack),
  .fifo_empty   (fifo_empty),
  .fifo_rd_en   (fifo_rd_en),
  .ptr_inc      (ptr_inc),
  .beat_accept  (beat_accept),
  .write_accept (write_accept),
  .hold_off     (hold_off)
);

// File: tb/burst_rd_asm_tb.sv
`timescale 1ns/1ps
module burst_rd_asm_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [15:0] cap_half = '0;
  logic        fifo_wr_en;
  logic [31:0] fifo_wr_data;
  logic        bus_cyc = 1'b0;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_cti = 3'd0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd_en;
  logic [31:0] fifo_rd_data = '0;
  logic        ptr_inc;

  int tests = 0;
  int fails = 0;
  int pops = 0;
  int acks = 0;
  int incs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_rd_asm u_dut (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_half(cap_half),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_cti(bus_cti),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .fifo_empty(fifo_empty),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .ptr_inc(ptr_inc)
  );

  // Behavioural first-word-fall-through FIFO.
  logic [31:0] q[$];
  logic        rd_s = 1'b0;
  logic        wr_s = 1'b0;
  logic [31:0] wd_s = '0;

  always @(negedge clk) begin
    #2;
    rd_s = fifo_rd_en;
    wr_s = fifo_wr_en;
    wd_s = fifo_wr_data;
    if (rst_n) begin
      if (bus_ack) acks++;
      if (ptr_inc) incs++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rd_s && q.size() > 0) begin
      void'(q.pop_front());
      pops++;
    end
    if (wr_s) q.push_back(wd_s);
    fifo_empty   = (q.size() == 0);
    fifo_rd_data = (q.size() > 0) ? q[0] : 32'h0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    cap_valid = 1'b1; cap_half = w[15:0];
    @(negedge clk);
    cap_half = w[31:16];
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  // One read beat; checks data, pointer increment and single-cycle ack.
  task automatic read_beat(input logic [2:0] tag, input logic [31:0] exp,
                           input bit keep_cyc);
    bit seen = 1'b0;
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b0; bus_cti = tag;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (bus_ack) seen = 1'b1;
    end
    check(seen, "R2 read ack", 32'(seen), 32'h1);
    check(bus_rdata == exp, "R3 read data", bus_rdata, exp);
    check(ptr_inc == 1'b1, "R4 ptr_inc with ack", 32'(ptr_inc), 32'h1);
    bus_stb = 1'b0;
    if (!keep_cyc) bus_cyc = 1'b0;
    @(negedge clk);
    check(bus_ack == 1'b0, "R7 ack single cycle", 32'(bus_ack), 32'h0);
  endtask

  task automatic t_reset;
    check(bus_ack == 1'b0, "R8 ack after reset", 32'(bus_ack), 32'h0);
    check(fifo_rd_en == 1'b0, "R8 rd_en after reset", 32'(fifo_rd_en), 32'h0);
    check(ptr_inc == 1'b0, "R8 ptr_inc after reset", 32'(ptr_inc), 32'h0);
    check(fifo_wr_en == 1'b0, "R8 wr_en after reset", 32'(fifo_wr_en), 32'h0);
  endtask

  task automatic t_pack;
    push_word(32'hBEEF_1234);
    wait_cycles(3);
    check(q.size() == 1, "R1 one word pushed", 32'(q.size()), 32'h1);
    check(q.size() > 0 && q[0] == 32'hBEEF_1234, "R1 half order",
          (q.size() > 0) ? q[0] : 32'hx, 32'hBEEF_1234);
    read_beat(3'd7, 32'hBEEF_1234, 1'b0);
  endtask

  task automatic t_burst;
    int p0;
    int a0;
    push_word(32'h0000_0A01);
    push_word(32'h0000_0A02);
    push_word(32'h0000_0A03);
    push_word(32'h0000_0A04);
    wait_cycles(3);
    p0 = pops; a0 = acks;
    read_beat(3'd2, 32'h0000_0A01, 1'b1);
    read_beat(3'd2, 32'h0000_0A02, 1'b1);
    read_beat(3'd2, 32'h0000_0A03, 1'b1);
    read_beat(3'd7, 32'h0000_0A04, 1'b0);
    check(pops - p0 == 4, "R3 one pop per beat", 32'(pops - p0), 32'd4);
    check(acks - a0 == 4, "R7 one ack per beat", 32'(acks - a0), 32'd4);
  endtask

  task automatic t_empty;
    bit seen = 1'b0;
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b0; bus_cti = 3'd2;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_ack) seen = 1'b1;
    end
    check(!seen, "R2 no ack while empty", 32'(seen), 32'h0);
    push_word(32'hCAFE_0055);
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (bus_ack) seen = 1'b1;
    end
    check(seen && bus_rdata == 32'hCAFE_0055, "R2 ack once word arrives",
          bus_rdata, 32'hCAFE_0055);
    bus_stb = 1'b0; bus_cyc = 1'b0;
    wait_cycles(2);
  endtask

  task automatic t_end_of_burst;
    bit seen = 1'b0;
    int i0;
    push_word(32'h1111_0001);
    push_word(32'h1111_0002);
    push_word(32'h1111_0003);
    wait_cycles(3);
    read_beat(3'd2, 32'h1111_0001, 1'b1);
    read_beat(3'd7, 32'h1111_0002, 1'b1);
    i0 = incs;
    bus_stb = 1'b1; bus_cti = 3'd2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bus_ack) seen = 1'b1;
    end
    check(!seen, "R5 no read after end tag", 32'(seen), 32'h0);
    check(q.size() == 1, "R5 FIFO untouched after end", 32'(q.size()), 32'h1);
    check(incs == i0, "R5 no pointer step after end", 32'(incs - i0), 32'h0);
    bus_stb = 1'b0; bus_cyc = 1'b0;
    @(negedge clk);
    read_beat(3'd2, 32'h1111_0003, 1'b0);
    // classic tag also closes the burst
    push_word(32'h2222_0001);
    push_word(32'h2222_0002);
    wait_cycles(3);
    read_beat(3'd0, 32'h2222_0001, 1'b1);
    seen = 1'b0;
    bus_stb = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_ack) seen = 1'b1;
    end
    check(!seen, "R5 classic tag ends burst", 32'(seen), 32'h0);
    bus_stb = 1'b0; bus_cyc = 1'b0;
    @(negedge clk);
    read_beat(3'd7, 32'h2222_0002, 1'b0);
  endtask

  task automatic t_write;
    int i0;
    int p0;
    push_word(32'h5A5A_A5A5);
    wait_cycles(3);
    i0 = incs; p0 = pops;
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_cti = 3'd7;
    @(negedge clk);
    check(bus_ack == 1'b1, "R6 write ack next cycle", 32'(bus_ack), 32'h1);
    check(ptr_inc == 1'b0, "R6 no ptr_inc on write", 32'(ptr_inc), 32'h0);
    bus_stb = 1'b0; bus_cyc = 1'b0; bus_we = 1'b0;
    wait_cycles(2);
    check(pops == p0 && q.size() == 1, "R6 write leaves FIFO",
          32'(q.size()), 32'h1);
    check(incs == i0, "R4 no increment for write", 32'(incs - i0), 32'h0);
    read_beat(3'd7, 32'h5A5A_A5A5, 1'b0);
  endtask

  initial begin
    wait_cycles(4);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset();
    t_pack();
    t_burst();
    t_empty();
    t_end_of_burst();
    t_write();
    wait_cycles(4);
    check(q.size() == 0, "R3 FIFO drained", 32'(q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule